// File: doc/BRIEF.md
# Accumulator CPU with Hardwired Control

This block is a compact processor core that runs programs out of one memory holding both code and data. Every instruction occupies one 16-bit word; the core works on an 8-bit accumulator and addresses 256 locations with an 8-bit address. A hardwired controller walks each instruction through a fixed set of states. It fetches the word at the program counter, latches it and advances the counter, then carries out the operation. Operations that read a data operand from memory take one further state.

The instruction set covers three groups, told apart by the top two opcode bits. The immediate group has move, add, subtract and bitwise AND with an 8-bit constant. The absolute group loads, stores, adds from and subtracts from a memory byte. The jump group has an unconditional jump and jumps taken on a zero or non-zero accumulator. There is no separate address or data buffer register: the operand is always the low byte of the instruction register, and memory data feed the datapath directly. If the program counter runs past the last location, the core stops and raises a sticky halt output. The memory is external, with one cycle of read latency.

Top module: `acc_cpu`

## Requirements
- R1: While reset is asserted the core presents address 0x00, keeps write enable low, keeps halt low and reports a zero accumulator (zero_o high).
- R2: The opcode sits in IR[15:12] and IR[11:8] is ignored. The operand is IR[7:0]. Data bytes are taken from bits 7:0 of a read word, and a store drives the accumulator on mem_wdata_o.
- R3: Each instruction takes three cycles (fetch with address = PC, decode, execute), and LOAD, ADDM and SUBM take a fourth. A STORE asserts write enable in its execute cycle, with the address set to the operand.
- R4: Immediate opcodes: 0 MOVE loads the constant, 1 ADD adds it, 2 SUB subtracts it and 3 AND ANDs it with the accumulator, all modulo 256.
- R5: Absolute opcodes: 4 LOAD copies the addressed byte to the accumulator, 5 STORE writes the accumulator to the addressed location, 6 ADDM adds the addressed byte and 7 SUBM subtracts it, all modulo 256.
- R6: Opcode 8 (unconditional jump) makes the operand the address of the next fetch.
- R7: Opcode 9 jumps only when the accumulator is zero, and opcode 10 only when it is non-zero. If the condition fails, execution continues at the next location.
- R8: zero_o is high exactly when the accumulator holds 0x00.
- R9: Opcodes 11 to 15 leave the accumulator unchanged and perform no write.
- R10: When the program counter would wrap from 0xFF to 0x00, halt_o rises and stays high. The word fetched from 0xFF is not executed, no further writes occur, and the memory address stays constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | 8 | Memory address (PC or operand) |
| mem_rdata_i | input | 16 | Memory read word, valid one cycle after the address |
| mem_wdata_o | output | 8 | Store data |
| mem_we_o | output | 1 | Memory write enable |
| halt_o | output | 1 | Sticky halt after a program-counter wrap |
| zero_o | output | 1 | Accumulator equals zero |

## Verification
The assertions check several things on every cycle: the program-counter step after decode, unconditional jump targets, a failed zero-jump leaving the counter alone, MOVE results, unused opcodes keeping the accumulator, the read state following memory-operand instructions, and the halt flag being sticky and quiet. The exact cycle counts per instruction class, and the arithmetic of the eight data operations over a sweep of operand pairs, only show in bench scenarios. The same holds for the stored results of conditional jumps across zero and non-zero accumulators, and for the point at which a program running off the end of memory stops.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;
  localparam int OPC_W = 4;

  localparam logic [OPC_W-1:0] OP_MOVE  = 4'd0;
  localparam logic [OPC_W-1:0] OP_ADD   = 4'd1;
  localparam logic [OPC_W-1:0] OP_SUB   = 4'd2;
  localparam logic [OPC_W-1:0] OP_AND   = 4'd3;
  localparam logic [OPC_W-1:0] OP_LOAD  = 4'd4;
  localparam logic [OPC_W-1:0] OP_STORE = 4'd5;
  localparam logic [OPC_W-1:0] OP_ADDM  = 4'd6;
  localparam logic [OPC_W-1:0] OP_SUBM  = 4'd7;
  localparam logic [OPC_W-1:0] OP_JMPU  = 4'd8;
  localparam logic [OPC_W-1:0] OP_JMPZ  = 4'd9;
  localparam logic [OPC_W-1:0] OP_JMPNZ = 4'd10;

  typedef enum logic [1:0] {ALU_PASS, ALU_ADD, ALU_SUB, ALU_AND} alu_op_e;
  typedef enum logic [1:0] {JMP_NONE, JMP_ALWAYS, JMP_IF_ZERO, JMP_IF_NZ} jmp_e;
  typedef enum logic [2:0] {ST_FETCH, ST_DECODE, ST_EXEC, ST_MEMRD, ST_HALT} state_e;

  typedef struct packed {
    alu_op_e alu_op;
    logic    acc_we;
    logic    mem_src;
    logic    mem_rd;
    logic    mem_wr;
    jmp_e    jmp;
  } ctrl_t;
endpackage

// File: rtl/acc_cpu_decode.sv
module acc_cpu_decode
  import acc_cpu_pkg::*;
(
  input  logic [OPC_W-1:0] opc_i,
  output ctrl_t            ctrl_o
);
  always_comb begin
    ctrl_o = '{alu_op: ALU_PASS, acc_we: 1'b0, mem_src: 1'b0,
               mem_rd: 1'b0, mem_wr: 1'b0, jmp: JMP_NONE};
    case (opc_i)
      OP_MOVE:  begin ctrl_o.alu_op = ALU_PASS; ctrl_o.acc_we = 1'b1; end
      OP_ADD:   begin ctrl_o.alu_op = ALU_ADD;  ctrl_o.acc_we = 1'b1; end
      OP_SUB:   begin ctrl_o.alu_op = ALU_SUB;  ctrl_o.acc_we = 1'b1; end
      OP_AND:   begin ctrl_o.alu_op = ALU_AND;  ctrl_o.acc_we = 1'b1; end
      OP_LOAD:  begin
        ctrl_o.alu_op = ALU_PASS; ctrl_o.acc_we = 1'b1;
        ctrl_o.mem_src = 1'b1;    ctrl_o.mem_rd = 1'b1;
      end
      OP_STORE: ctrl_o.mem_wr = 1'b1;
      OP_ADDM:  begin
        ctrl_o.alu_op = ALU_ADD; ctrl_o.acc_we = 1'b1;
        ctrl_o.mem_src = 1'b1;   ctrl_o.mem_rd = 1'b1;
      end
      OP_SUBM:  begin
        ctrl_o.alu_op = ALU_SUB; ctrl_o.acc_we = 1'b1;
        ctrl_o.mem_src = 1'b1;   ctrl_o.mem_rd = 1'b1;
      end
      OP_JMPU:  ctrl_o.jmp = JMP_ALWAYS;
      OP_JMPZ:  ctrl_o.jmp = JMP_IF_ZERO;
      OP_JMPNZ: ctrl_o.jmp = JMP_IF_NZ;
      default:  ;
    endcase
  end
endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] y_o
);
  always_comb begin
    case (op_i)
      ALU_ADD: y_o = a_i + b_i;
      ALU_SUB: y_o = a_i - b_i;
      ALU_AND: y_o = a_i & b_i;
      default: y_o = b_i;
    endcase
  end
endmodule

// File: rtl/acc_cpu_seq.sv
module acc_cpu_seq
  import acc_cpu_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int INSTR_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [INSTR_W-1:0] rdata_i,
  input  logic               mem_rd_i,
  input  logic               jump_take_i,
  input  logic [ADDR_W-1:0]  jump_tgt_i,
  output state_e             state_o,
  output logic [ADDR_W-1:0]  pc_o,
  output logic [INSTR_W-1:0] ir_o,
  output logic               halt_o
);
  localparam logic [ADDR_W-1:0] PC_LAST = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o <= ST_FETCH;
      pc_o    <= '0;
      ir_o    <= '0;
      halt_o  <= 1'b0;
    end else begin
      case (state_o)
        ST_FETCH:  state_o <= ST_DECODE;
        ST_DECODE: begin
          ir_o <= rdata_i;
          if (pc_o == PC_LAST) begin
            halt_o  <= 1'b1;
            state_o <= ST_HALT;
          end else begin
            pc_o    <= pc_o + 1'b1;
            state_o <= ST_EXEC;
          end
        end
        ST_EXEC: begin
          if (jump_take_i) pc_o <= jump_tgt_i;
          state_o <= mem_rd_i ? ST_MEMRD : ST_FETCH;
        end
        ST_MEMRD:  state_o <= ST_FETCH;
        ST_HALT:   state_o <= ST_HALT;
        default:   state_o <= ST_FETCH;
      endcase
    end
  end

  a_r3_pc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_DECODE && pc_o != PC_LAST) |=> pc_o == ADDR_W'($past(pc_o) + 1'b1));
  a_r3_memrd_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_EXEC && mem_rd_i) |=> state_o == ST_MEMRD);
  a_r10_wrap_halts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_DECODE && pc_o == PC_LAST) |=> halt_o);
  a_r10_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> halt_o);
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 8,
  parameter int INSTR_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  output logic [ADDR_W-1:0]  mem_addr_o,
  input  logic [INSTR_W-1:0] mem_rdata_i,
  output logic [DATA_W-1:0]  mem_wdata_o,
  output logic               mem_we_o,
  output logic               halt_o,
  output logic               zero_o
);
  localparam int OPC_LSB = INSTR_W - OPC_W;

  state_e             state;
  logic [ADDR_W-1:0]  pc;
  logic [INSTR_W-1:0] ir;
  logic [OPC_W-1:0]   opc;
  ctrl_t              ctrl;
  logic [DATA_W-1:0]  acc_q;
  logic [DATA_W-1:0]  alu_b;
  logic [DATA_W-1:0]  alu_y;
  logic               acc_load;
  logic               jump_take;

  assign opc = ir[INSTR_W-1:OPC_LSB];

  acc_cpu_decode u_decode (
    .opc_i  (opc),
    .ctrl_o (ctrl)
  );

  acc_cpu_seq #(.ADDR_W(ADDR_W), .INSTR_W(INSTR_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rdata_i     (mem_rdata_i),
    .mem_rd_i    (ctrl.mem_rd),
    .jump_take_i (jump_take),
    .jump_tgt_i  (ir[ADDR_W-1:0]),
    .state_o     (state),
    .pc_o        (pc),
    .ir_o        (ir),
    .halt_o      (halt_o)
  );

  // Operand is a bit slice: constant from IR or byte from memory data
  assign alu_b = ctrl.mem_src ? mem_rdata_i[DATA_W-1:0] : ir[DATA_W-1:0];

  acc_cpu_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i (ctrl.alu_op),
    .a_i  (acc_q),
    .b_i  (alu_b),
    .y_o  (alu_y)
  );

  assign zero_o = (acc_q == '0);

  always_comb begin
    case (ctrl.jmp)
      JMP_ALWAYS:  jump_take = 1'b1;
      JMP_IF_ZERO: jump_take = zero_o;
      JMP_IF_NZ:   jump_take = !zero_o;
      default:     jump_take = 1'b0;
    endcase
  end

  assign acc_load = ctrl.acc_we &&
                    ((state == ST_EXEC && !ctrl.mem_rd) || state == ST_MEMRD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       acc_q <= '0;
    else if (acc_load) acc_q <= alu_y;
  end

  assign mem_addr_o  = (state == ST_EXEC && (ctrl.mem_rd || ctrl.mem_wr)) ?
                       ir[ADDR_W-1:0] : pc;
  assign mem_we_o    = (state == ST_EXEC) && ctrl.mem_wr;
  assign mem_wdata_o = acc_q;

  a_r4_move: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_EXEC && opc == OP_MOVE) |=> acc_q == $past(ir[DATA_W-1:0]));
  a_r6_jumpu: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_EXEC && opc == OP_JMPU) |=> pc == $past(ir[ADDR_W-1:0]));
  a_r7_jz_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_EXEC && opc == OP_JMPZ && acc_q != '0) |=> pc == $past(pc));
  a_r9_nop_keeps_acc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_EXEC && opc > OP_JMPNZ) |=> $stable(acc_q));
  a_r10_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_o && $past(halt_o)) |-> (!mem_we_o && $stable(mem_addr_o)));
endmodule

// File: tb/acc_cpu_tb.sv
module acc_cpu_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  mem_addr;
  logic [15:0] mem_rdata;
  logic [7:0]  mem_wdata;
  logic        mem_we;
  logic        halt;
  logic        zero;

  logic [15:0] mem [256];
  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  acc_cpu u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .mem_addr_o  (mem_addr),
    .mem_rdata_i (mem_rdata),
    .mem_wdata_o (mem_wdata),
    .mem_we_o    (mem_we),
    .halt_o      (halt),
    .zero_o      (zero)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= {8'h00, mem_wdata};
    mem_rdata <= mem[mem_addr];
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000 && !done) begin
      failures = failures + 1;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<190000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic [15:0] ins(input logic [3:0] op, input logic [7:0] opr);
    return {op, 4'hA, opr};  // IR[11:8] filled with junk (R2)
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      failures = failures + 1;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
  endtask

  task automatic restart(input int n);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [7:0] a, b, v;
    bit         we_seen;
    int         we_at;

    // R1: reset state
    clear_mem();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 addr", {8'h0, mem_addr}, 16'h0000);
    chk("R1 we", {15'h0, mem_we}, 16'h0000);
    chk("R1 halt", {15'h0, halt}, 16'h0000);
    chk("R1 zero", {15'h0, zero}, 16'h0001);

    // R3 / R2: cycle timing and low-byte data path
    clear_mem();
    mem[0]    = ins(4'd0, 8'h05);
    mem[1]    = ins(4'd4, 8'h20);
    mem[2]    = ins(4'd5, 8'h21);
    mem[3]    = ins(4'd8, 8'h03);
    mem[8'h20] = {8'hC3, 8'h77};
    we_seen = 1'b0;
    we_at = -1;
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    for (int n = 0; n < 14; n++) begin
      if (n > 0) @(negedge clk);
      #1;
      if (n == 0) chk("R3 fetch0 addr", {8'h0, mem_addr}, 16'h0000);
      if (n == 3) chk("R3 fetch1 addr", {8'h0, mem_addr}, 16'h0001);
      if (n == 5) chk("R3 load operand addr", {8'h0, mem_addr}, 16'h0020);
      if (n == 7) chk("R3 fetch2 addr after 4-cycle load", {8'h0, mem_addr}, 16'h0002);
      if (mem_we && !we_seen) begin
        we_seen = 1'b1;
        we_at = n;
        chk("R3 store addr", {8'h0, mem_addr}, 16'h0021);
        chk("R2 store data low byte", {8'h0, mem_wdata}, 16'h0077);
      end
    end
    chk("R3 store cycle", 16'(we_at), 16'd9);
    chk("R2 stored word", mem[8'h21], 16'h0077);

    // R4 / R5 / R8: operand sweep over immediate and absolute operations
    for (int ia = 0; ia < 16; ia++) begin
      for (int ib = 0; ib < 16; ib++) begin
        a = 8'(ia * 17);
        b = (ib == 15) ? 8'hFF : 8'(ib * 37);
        clear_mem();
        mem[0]  = ins(4'd0, a);     mem[1]  = ins(4'd1, b);     mem[2]  = ins(4'd5, 8'hE0);
        mem[3]  = ins(4'd0, a);     mem[4]  = ins(4'd2, b);     mem[5]  = ins(4'd5, 8'hE1);
        mem[6]  = ins(4'd0, a);     mem[7]  = ins(4'd3, b);     mem[8]  = ins(4'd5, 8'hE2);
        mem[9]  = ins(4'd4, 8'hD0); mem[10] = ins(4'd5, 8'hE3);
        mem[11] = ins(4'd0, a);     mem[12] = ins(4'd6, 8'hD0); mem[13] = ins(4'd5, 8'hE4);
        mem[14] = ins(4'd0, a);     mem[15] = ins(4'd7, 8'hD0); mem[16] = ins(4'd5, 8'hE5);
        mem[17] = ins(4'd8, 8'd17);
        mem[8'hD0] = {8'h5A, b};
        restart(70);
        chk("R4 ADD", mem[8'hE0], {8'h0, 8'(a + b)});
        chk("R4 SUB", mem[8'hE1], {8'h0, 8'(a - b)});
        chk("R4 AND", mem[8'hE2], {8'h0, a & b});
        chk("R5 LOAD", mem[8'hE3], {8'h0, b});
        chk("R5 ADDM", mem[8'hE4], {8'h0, 8'(a + b)});
        chk("R5 SUBM", mem[8'hE5], {8'h0, 8'(a - b)});
        chk("R8 zero flag", {15'h0, zero}, {15'h0, (8'(a - b) == 8'h00)});
      end
    end

    // R6: unconditional jump
    clear_mem();
    mem[0]     = ins(4'd8, 8'h40);
    mem[1]     = ins(4'd0, 8'h11);
    mem[2]     = ins(4'd5, 8'hE0);
    mem[8'h40] = ins(4'd0, 8'h22);
    mem[8'h41] = ins(4'd5, 8'hE0);
    mem[8'h42] = ins(4'd8, 8'h42);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    chk("R6 next fetch at target", {8'h0, mem_addr}, 16'h0040);
    repeat (20) @(negedge clk);
    chk("R6 skipped path", mem[8'hE0], 16'h0022);

    // R7: conditional jumps on zero and non-zero accumulator
    for (int k = 0; k < 4; k++) begin
      v = (k == 0) ? 8'h00 : (k == 1) ? 8'h01 : (k == 2) ? 8'h80 : 8'hFF;
      clear_mem();
      mem[0]  = ins(4'd0, v);     mem[1]  = ins(4'd9, 8'd4);
      mem[2]  = ins(4'd0, 8'hAA); mem[3]  = ins(4'd8, 8'd5);
      mem[4]  = ins(4'd0, 8'h55); mem[5]  = ins(4'd5, 8'hE0);
      mem[6]  = ins(4'd0, v);     mem[7]  = ins(4'd10, 8'd10);
      mem[8]  = ins(4'd0, 8'hAA); mem[9]  = ins(4'd8, 8'd11);
      mem[10] = ins(4'd0, 8'h55); mem[11] = ins(4'd5, 8'hE1);
      mem[12] = ins(4'd8, 8'd12);
      restart(60);
      chk("R7 JUMPZ", mem[8'hE0], (v == 8'h00) ? 16'h0055 : 16'h00AA);
      chk("R7 JUMPNZ", mem[8'hE1], (v != 8'h00) ? 16'h0055 : 16'h00AA);
      chk("R8 zero after jumps", {15'h0, zero}, 16'h0000);
    end

    // R9 / R10: unused opcodes run to the end of memory, then wrap halts
    clear_mem();
    mem[0] = ins(4'd0, 8'h33);
    for (int i = 1; i < 8'hFE; i++) mem[i] = ins(4'(11 + (i % 5)), 8'(i));
    mem[8'hFE] = ins(4'd5, 8'h11);
    mem[8'hFF] = ins(4'd5, 8'h10);
    restart(760);
    chk("R10 no halt before wrap", {15'h0, halt}, 16'h0000);
    repeat (10) @(negedge clk);
    chk("R10 halt after wrap", {15'h0, halt}, 16'h0001);
    chk("R9 acc kept through unused opcodes", mem[8'h11], 16'h0033);
    chk("R9 zero stays low", {15'h0, zero}, 16'h0000);
    chk("R10 word at 0xFF not executed", mem[8'h10], ins(4'(11 + (16 % 5)), 8'h10));
    chk("R10 addr held", {8'h0, mem_addr}, 16'h00FF);
    we_seen = 1'b0;
    for (int n = 0; n < 20; n++) begin
      @(negedge clk);
      if (mem_we) we_seen = 1'b1;
    end
    chk("R10 no write while halted", {15'h0, we_seen}, 16'h0000);
    chk("R10 halt sticky", {15'h0, halt}, 16'h0001);
    chk("R10 addr still held", {8'h0, mem_addr}, 16'h00FF);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule